// File: doc/BRIEF.md
# Selective-Parity Instruction Queue with Column Interleaving

This block is a slot-addressed instruction queue in which every stored word is written in a reordered physical column order. A single even-parity bit per slot covers only a small, evenly spaced set of physical columns. Those columns hold the most critical logical fields, with the valid flag in the top logical bit, the issued flag below it, and the reorder-buffer tag under that. The least critical logical bits are packed into the columns beside each protected column. As a result, a horizontal upset a few bits wide can disturb at most one protected column, and the parity bit sees it.

Up to `WP` instructions are written per cycle, each on its own port with a valid strobe and a slot index. A single read port returns any slot in logical field order within the same cycle. When a read is enabled and the recomputed parity of the addressed slot disagrees with the stored bit, `rd_err` rises at once. At the next clock edge every slot is cleared and `flush` is driven high for one cycle, so the surrounding pipeline can restart from its last committed instruction. An upset-injection port flips chosen physical columns of one slot. Fault campaigns use it to model particle strikes.

Both the column map and the protected set come from parameters at elaboration time: the word width `W`, the number of protected columns `PROT`, and the spacing `W/PROT` that follows from them.

Top module: `sp_iq`

## Requirements
- R1: While `rst` is high, and after its release, every slot reads as all zeros with `rd_err` low, and `flush` is low.
- R2: A word written on any port at a clock edge is returned unchanged in logical order by a read of that slot in any later cycle, with `rd_err` low, as long as no upset touched it.
- R3: When several ports write the same slot in the same cycle, the highest-numbered port's data is stored.
- R4: Physical column `k*S` (with `S = W/PROT` and `k` from 0 to `PROT-1`) holds logical bit `W-1-k`. With the defaults (W=219, PROT=22, S=9), physical 0 holds the valid bit 218 and physical 9 holds the issued bit 217.
- R5: The remaining logical bits are assigned from bit 0 upward to the free physical positions in this order: every protected position plus 1, then every one minus 1, then plus 2, then minus 2, and so on. Positions outside the word or already taken are skipped. With the defaults, physical 1 holds logical 0, physical 10 holds logical 1, and physical 8 holds logical 22.
- R6: The stored parity bit equals the XOR of the protected physical columns. With `rd_en` high, `rd_err` is high in the same cycle exactly when the recomputed and stored parity differ. A flip on an unprotected column is not detected, but it appears in `rd_data`.
- R7: After a cycle with `rd_err` high, at the next edge all slots are cleared and `flush` is high for exactly one cycle. Writes and upsets presented in the detecting cycle are discarded.
- R8: Flipping two protected columns of one slot cancels in parity, and `rd_err` stays low. For this reason elaboration rejects any spacing `S` below 4.
- R9: A parity mismatch on a slot that is not read with `rd_en` high raises no flush.
- R10: `inj_en` XORs `inj_mask` into the physical columns of slot `inj_slot` at the clock edge, applied after any write to that slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | WP | Per-port write strobe |
| wr_slot | input | WP*log2(SLOTS) | Per-port slot index, port i at bits [i*SW +: SW] |
| wr_data | input | WP*W | Per-port logical word, port i at bits [i*W +: W] |
| rd_en | input | 1 | Read enable; arms parity checking |
| rd_slot | input | log2(SLOTS) | Slot to read |
| rd_data | output | W | Addressed slot in logical order |
| rd_err | output | 1 | Parity mismatch on an enabled read |
| flush | output | 1 | One-cycle flush request after a detected error |
| inj_en | input | 1 | Apply an upset this cycle |
| inj_slot | input | log2(SLOTS) | Slot struck by the upset |
| inj_mask | input | W | Physical columns to invert |

## Verification
The main function is tested with three kinds of input patterns. Full-queue writes on all four ports with slot-dependent data check that the permutation and its inverse round-trip. Same-slot multi-port writes check port priority. Single-column upsets at known physical positions show where a stored bit actually lives: an unprotected strike flips one predicted logical bit without an error, and a protected strike raises an error that leads to a flush. A double protected strike shows that parity cancels. A mismatch left unread shows that detection depends on `rd_en`. A write issued in the detecting cycle shows that the flush takes precedence.

// File: rtl/sp_iq.sv
module sp_iq #(
  parameter int SLOTS = 32,
  parameter int W     = 219,
  parameter int WP    = 4,
  parameter int PROT  = 22
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [WP-1:0]                 wr_en,
  input  logic [WP*$clog2(SLOTS)-1:0]   wr_slot,
  input  logic [WP*W-1:0]               wr_data,
  input  logic                          rd_en,
  input  logic [$clog2(SLOTS)-1:0]      rd_slot,
  output logic [W-1:0]                  rd_data,
  output logic                          rd_err,
  output logic                          flush,
  input  logic                          inj_en,
  input  logic [$clog2(SLOTS)-1:0]      inj_slot,
  input  logic [W-1:0]                  inj_mask
);
  localparam int SW     = $clog2(SLOTS);
  localparam int IW     = $clog2(W);
  localparam int STRIDE = W / PROT;

  if (STRIDE < 4) begin : g_bad_spacing
    $error("protected column spacing must be at least 4");
  end

  function automatic logic [W*IW-1:0] build_map();
    logic [W*IW-1:0] m;
    logic [W-1:0]    used;
    int nxt, off, pos;
    m = '0;
    used = '0;
    for (int k = 0; k < PROT; k++) begin
      m[k*STRIDE*IW +: IW] = IW'(W-1-k);
      used[k*STRIDE] = 1'b1;
    end
    nxt = 0;
    off = 1;
    while (nxt < W-PROT) begin
      for (int k = 0; k < PROT; k++) begin
        pos = k*STRIDE + off;
        if (nxt < W-PROT && pos >= 0 && pos < W) begin
          if (!used[pos]) begin
            m[pos*IW +: IW] = IW'(nxt);
            used[pos] = 1'b1;
            nxt++;
          end
        end
      end
      off = (off > 0) ? -off : 1 - off;
    end
    return m;
  endfunction

  function automatic logic [W-1:0] build_mask();
    logic [W-1:0] mk;
    mk = '0;
    for (int k = 0; k < PROT; k++) mk[k*STRIDE] = 1'b1;
    return mk;
  endfunction

  localparam logic [W*IW-1:0] P2L   = build_map();
  localparam logic [W-1:0]    PMASK = build_mask();

  logic [W:0]   mem [SLOTS];
  logic [W-1:0] wphys [WP];
  logic [WP-1:0] wpar;
  logic [W:0]   rd_word;
  logic [W:0]   inj_base;
  logic         flush_q;

  for (genvar gi = 0; gi < WP; gi++) begin : g_port
    for (genvar gp = 0; gp < W; gp++) begin : g_col
      localparam int LI = int'(P2L[gp*IW +: IW]);
      assign wphys[gi][gp] = wr_data[gi*W + LI];
    end
    assign wpar[gi] = ^(wphys[gi] & PMASK);
  end

  assign rd_word = mem[rd_slot];
  for (genvar gp = 0; gp < W; gp++) begin : g_rd
    localparam int LI = int'(P2L[gp*IW +: IW]);
    assign rd_data[LI] = rd_word[gp];
  end

  assign rd_err = rd_en && ((^(rd_word[W-1:0] & PMASK)) != rd_word[W]);
  assign flush  = flush_q;

  always_comb begin
    inj_base = mem[inj_slot];
    for (int i = 0; i < WP; i++)
      if (wr_en[i] && wr_slot[i*SW +: SW] == inj_slot)
        inj_base = {wpar[i], wphys[i]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q <= 1'b0;
      for (int s = 0; s < SLOTS; s++) mem[s] <= '0;
    end else begin
      flush_q <= rd_err;
      if (rd_err) begin
        for (int s = 0; s < SLOTS; s++) mem[s] <= '0;
      end else begin
        for (int i = 0; i < WP; i++)
          if (wr_en[i]) mem[wr_slot[i*SW +: SW]] <= {wpar[i], wphys[i]};
        if (inj_en) mem[inj_slot] <= inj_base ^ {1'b0, inj_mask};
      end
    end
  end

  assert_wr_rd_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_en[WP-1]) && !$past(rd_err) && !$past(inj_en) &&
     rd_slot == $past(wr_slot[(WP-1)*SW +: SW]))
    |-> (rd_data == $past(wr_data[(WP-1)*W +: W]) && !rd_err));

  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (rst)
    flush |-> (rd_data == '0 && !rd_err));

  assert_flush_single_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  assert_flush_needs_read_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(flush) |-> $past(rd_en));
endmodule

// File: tb/test_sp_iq.sv
module test_sp_iq;
  localparam int SLOTS = 32;
  localparam int W     = 219;
  localparam int WP    = 4;
  localparam int SW    = 5;

  logic                 clk = 0;
  logic                 rst;
  logic [WP-1:0]        wr_en;
  logic [WP*SW-1:0]     wr_slot;
  logic [WP*W-1:0]      wr_data;
  logic                 rd_en;
  logic [SW-1:0]        rd_slot;
  logic [W-1:0]         rd_data;
  logic                 rd_err;
  logic                 flush;
  logic                 inj_en;
  logic [SW-1:0]        inj_slot;
  logic [W-1:0]         inj_mask;

  always #4 clk = ~clk;

  sp_iq #(.SLOTS(SLOTS), .W(W), .WP(WP), .PROT(22)) i_sp_iq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
    .rd_en(rd_en), .rd_slot(rd_slot), .rd_data(rd_data), .rd_err(rd_err),
    .flush(flush), .inj_en(inj_en), .inj_slot(inj_slot), .inj_mask(inj_mask));

  typedef struct {
    logic [W-1:0] data;
    logic         err;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [W-1:0] model [SLOTS];
  int           checks = 0;
  int           fails  = 0;
  bit           done   = 0;

  function automatic logic [W-1:0] pat(int s, int v);
    logic [223:0] t;
    t = {7{32'(s) * 32'h9E3779B1 ^ 32'(v) * 32'h85EBCA6B}};
    return t[W-1:0];
  endfunction

  task automatic cyc();
    @(negedge clk);
    wr_en  = '0;
    rd_en  = 1'b0;
    inj_en = 1'b0;
    inj_mask = '0;
  endtask

  task automatic put_wr(int p, int s, logic [W-1:0] d);
    wr_en[p] = 1'b1;
    wr_slot[p*SW +: SW] = SW'(s);
    wr_data[p*W +: W] = d;
  endtask

  task automatic put_rd(int s, logic [W-1:0] d, logic e, string tag);
    exp_t x;
    rd_en = 1'b1;
    rd_slot = SW'(s);
    x.data = d; x.err = e; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic check_flush(logic e, string tag);
    #2;
    checks++;
    if (flush !== e) begin
      fails++;
      $display("FAIL %s flush actual=%b expected=%b", tag, flush, e);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rd_en) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard read with no expected item actual=%h expected=none", rd_data);
      end else begin
        exp_t x;
        x = sb.pop_front();
        checks++;
        if (rd_data !== x.data || rd_err !== x.err) begin
          fails++;
          $display("FAIL %s data actual=%h err=%b expected=%h err=%b",
                   x.tag, rd_data, rd_err, x.data, x.err);
        end
      end
    end
  end

  initial begin
    #(8*100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] m;
    rst = 1'b1; wr_en = '0; wr_slot = '0; wr_data = '0; rd_en = 0; rd_slot = '0;
    inj_en = 0; inj_slot = '0; inj_mask = '0;
    for (int s = 0; s < SLOTS; s++) model[s] = '0;
    repeat (3) cyc();
    rst = 1'b0;

    // R1: reset state
    cyc(); put_rd(0, '0, 1'b0, "R1 slot0"); check_flush(1'b0, "R1");
    cyc(); put_rd(31, '0, 1'b0, "R1 slot31");

    // R2: fill every slot through all four ports, then read all back
    for (int c = 0; c < SLOTS/WP; c++) begin
      cyc();
      for (int p = 0; p < WP; p++) begin
        model[c*WP+p] = pat(c*WP+p, p);
        put_wr(p, c*WP+p, model[c*WP+p]);
      end
    end
    for (int s = 0; s < SLOTS; s++) begin
      cyc(); put_rd(s, model[s], 1'b0, "R2 roundtrip");
    end

    // R3: same-slot write on all ports, highest port wins
    cyc();
    for (int p = 0; p < WP; p++) put_wr(p, 5, pat(500, p));
    model[5] = pat(500, WP-1);
    cyc(); put_rd(5, model[5], 1'b0, "R3 port priority");

    // R5 R6 R10: unprotected strikes flip predicted logical bits, no error
    cyc(); inj_en = 1; inj_slot = 2; inj_mask = '0; inj_mask[1] = 1'b1;
    model[2][0] = ~model[2][0];
    cyc(); put_rd(2, model[2], 1'b0, "R5 phys1->log0 R6 undetected");
    cyc(); inj_en = 1; inj_slot = 3; inj_mask = '0; inj_mask[10] = 1'b1;
    model[3][1] = ~model[3][1];
    cyc(); put_rd(3, model[3], 1'b0, "R5 phys10->log1");
    cyc(); inj_en = 1; inj_slot = 8; inj_mask = '0; inj_mask[8] = 1'b1;
    model[8][22] = ~model[8][22];
    cyc(); put_rd(8, model[8], 1'b0, "R5 phys8->log22");

    // R10: upset applied after same-cycle write to the same slot
    cyc(); put_wr(0, 12, pat(1200, 0)); inj_en = 1; inj_slot = 12;
    inj_mask = '0; inj_mask[1] = 1'b1;
    model[12] = pat(1200, 0); model[12][0] = ~model[12][0];
    cyc(); put_rd(12, model[12], 1'b0, "R10 write then upset");

    // R4 R8: two protected columns cancel; they hold logical 218 and 217
    cyc(); inj_en = 1; inj_slot = 4; inj_mask = '0; inj_mask[0] = 1'b1; inj_mask[9] = 1'b1;
    model[4][218] = ~model[4][218]; model[4][217] = ~model[4][217];
    cyc(); put_rd(4, model[4], 1'b0, "R4 R8 double protected cancels");

    // R9: mismatch left unread raises no flush
    cyc(); inj_en = 1; inj_slot = 6; inj_mask = '0; inj_mask[9] = 1'b1;
    model[6][217] = ~model[6][217];
    cyc(); rd_slot = 6;
    cyc(); check_flush(1'b0, "R9 unread mismatch");

    // R6 R4: enabled read detects, protected phys 9 is logical 217
    // R7: same-cycle write is discarded, all slots cleared, one-cycle flush
    m = model[6];
    cyc(); put_rd(6, m, 1'b1, "R6 detect R4 phys9->log217");
    put_wr(0, 7, pat(700, 0));
    for (int s = 0; s < SLOTS; s++) model[s] = '0;
    cyc(); put_rd(7, '0, 1'b0, "R7 dropped write cleared"); check_flush(1'b1, "R7 flush");
    cyc(); put_rd(0, '0, 1'b0, "R7 slot0 cleared"); check_flush(1'b0, "R7 flush single");
    cyc(); put_rd(31, '0, 1'b0, "R7 slot31 cleared");

    // R2 after flush: queue usable again
    cyc(); put_wr(1, 9, pat(900, 1)); model[9] = pat(900, 1);
    cyc(); put_rd(9, model[9], 1'b0, "R2 after flush");

    cyc(); cyc();
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule